// File: doc/BRIEF.md
# Capability Manipulation Unit

This block is the execute stage for operations that reshape capabilities: bounded, typed, permission-carrying pointers held in tagged registers. Each issue presents an operation code, three decoded register operands (first source, second source and the current destination content) and a 12-bit immediate. The unit checks every legality rule of the operation. One clock edge later it reports one of two outcomes. Either it gives the new destination value and, where the operation also changes its source, the new source value. Or it raises a single-cycle exception strobe with a cause code and performs no write.

A tagged operand is either an integer or a capability. When it is an integer, its value travels in the cursor field and the other fields carry no meaning. The unit holds no register storage and does no decode. Invalidation sweeps over memory are handled elsewhere. The surrounding pipeline writes `rd_val_o` and `rs_val_o` back to the register file when the matching write enable is high.

Top module: `capx_unit`

## Requirements
- R1: Operand layout, MSB to LSB: is_cap (1), valid (1), type (3), perms (3), count (5), cursor, base, end (ADDR_W each). Operation codes are: move 0, increment by register 1, increment by immediate 2, cursor set 3, cursor get 4, shrink 5, split 6, tighten 7, delinearise 8, initialise 9, seal 10, drop 11, make-revocation 12. Results appear on the cycle after the edge that samples `go_i`. After reset, and on any cycle with no issue on the edge before, both write enables and `exc_o` are 0.
- R2: Type codes: 0 linear, 1 non-linear, 2 revocation, 3 uninitialised, 4 sealed, 5 sealed-return. An operand of the wrong kind (integer or capability) raises cause 1. An unknown operation code raises cause 7. When several checks fail, the reported cause follows this priority: 7, then 1, 2 (invalid source), 3 (type), 4 (permission), 5 (bounds), 6 (count).
- R3: A move with distinct registers copies source 1 to the destination. It also writes the source back as the null capability (is_cap 1, every other field 0) unless the source type is 1. A move with `same_reg_i` high writes nothing.
- R4: Cursor increment adds the second source value, or the sign-extended immediate, to the cursor of a moved copy of source 1. Type 3 raises cause 3. A zero offset behaves exactly as a move.
- R5: Cursor set writes the integer from source 1 into the destination's cursor; types 3, 4 and 5 raise cause 3. Cursor get returns source 1's cursor as an integer with all other fields zero; types 4 and 5 raise cause 3.
- R6: Shrink sets the destination bounds to [source 1, source 2). It needs type 0, 1 or 3 (else cause 3). A lower bound above the upper bound, or a range not inside the old bounds, raises cause 5.
- R7: Split needs source 1 of type 0 or 1 and a point p within [base, end] inclusive (else cause 5). The source gets end = p, and the destination is a copy with base = p.
- R8: Tighten replaces the destination perms (0 none, 1 R, 2 RX, 3 RW, 4 RWX). It needs type 0, 1 or 3. A new value above 4, or one not at or below the old value, raises cause 4. Under the order, 0 is below all, 1 is below 2, 3 and 4, 2 and 3 are below 4, and 2 and 3 are incomparable.
- R9: Delinearise needs type 0 and sets type 1. Initialise needs type 3 (else cause 3) and cursor equal to end (else cause 5), and sets type 0.
- R10: Seal needs type 0 (cause 3), perms 3 or 4 (cause 4), and end - base of at least 4096 (cause 5). It also needs an integer count no greater than 31 (cause 6). It sets type 4 and stores the count.
- R11: Drop writes source 1 back with valid 0 and no destination write. Make-revocation needs source 1 valid (cause 2) and of type 0 (cause 3), and writes a copy of it with type 2 to the destination.
- R12: On any fault, `exc_o` is high for one cycle with a non-zero `cause_o` and both write enables low. Without a fault, `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Issue strobe for the operands presented this cycle |
| op_i | input | 4 | Operation code |
| same_reg_i | input | 1 | Source 1 and destination name the same register |
| imm_i | input | IMM_W | Immediate offset |
| src1_i | input | OPND_W | First source operand |
| src2_i | input | OPND_W | Second source operand |
| dst_i | input | OPND_W | Current destination content |
| rd_we_o | output | 1 | Destination write enable |
| rd_val_o | output | OPND_W | New destination value |
| rs_we_o | output | 1 | Source 1 write-back enable |
| rs_val_o | output | OPND_W | New source 1 value |
| exc_o | output | 1 | Exception strobe |
| cause_o | output | 3 | Exception cause |

## Verification
Every result of this block (destination value, source write-back, exception strobe and cause) is due exactly one rising edge after the issue. The bench drives the operands and `go_i` on a falling edge, lowers `go_i` on the next falling edge, and compares all outputs at that same point, after a single registering edge. The strobe and the write enables must drop again one cycle later. Idle checks sample them on the following falling edge with no issue pending.

// File: rtl/capx_pkg.sv
package capx_pkg;

   typedef enum logic [3:0] {
      OP_MOVE    = 4'd0,
      OP_INCR    = 4'd1,
      OP_INCI    = 4'd2,
      OP_CSET    = 4'd3,
      OP_CGET    = 4'd4,
      OP_SHRINK  = 4'd5,
      OP_SPLIT   = 4'd6,
      OP_TIGHTEN = 4'd7,
      OP_DELIN   = 4'd8,
      OP_INIT    = 4'd9,
      OP_SEAL    = 4'd10,
      OP_DROP    = 4'd11,
      OP_MKREV   = 4'd12
   } op_e;

   typedef enum logic [2:0] {
      C_NONE    = 3'd0,
      C_KIND    = 3'd1,
      C_INVALID = 3'd2,
      C_TYPE    = 3'd3,
      C_PERM    = 3'd4,
      C_BOUNDS  = 3'd5,
      C_COUNT   = 3'd6,
      C_BADOP   = 3'd7
   } cause_e;

   localparam logic [2:0] T_LIN    = 3'd0;
   localparam logic [2:0] T_NLIN   = 3'd1;
   localparam logic [2:0] T_REV    = 3'd2;
   localparam logic [2:0] T_UNINIT = 3'd3;
   localparam logic [2:0] T_SEALED = 3'd4;
   localparam logic [2:0] T_SRET   = 3'd5;

   localparam int PERM_W    = 3;
   localparam int PERM_TOP  = 4;
   localparam int COUNT_W   = 5;
   localparam int COUNT_MAX = 31;
   localparam int META_W    = 2 + 3 + PERM_W + COUNT_W;

endpackage

// File: rtl/capx_perm_order.sv
module capx_perm_order #(
   parameter int PERM_W     = 3,
   parameter int PERM_TOP   = 4,
   parameter bit TABLE_IMPL = 1'b0
) (
   input  logic [PERM_W-1:0] new_i,
   input  logic [PERM_W-1:0] old_i,
   output logic              le_o
);
   localparam int LVLS = PERM_TOP + 1;

   if (PERM_TOP != 4) begin : g_bad_top
      $error("capx_perm_order: ordering is defined for five levels only");
   end

   if (TABLE_IMPL) begin : g_table
      function automatic logic [LVLS*LVLS-1:0] build_map();
         logic [LVLS*LVLS-1:0] m;
         m = '0;
         for (int n = 0; n < LVLS; n++) begin
            for (int o = 0; o < LVLS; o++) begin
               m[n*LVLS+o] = (n == o) || (n == 0) || (n == 1 && o != 0) || (o == PERM_TOP);
            end
         end
         return m;
      endfunction
      localparam logic [LVLS*LVLS-1:0] LE_MAP = build_map();
      always_comb begin
         le_o = 1'b0;
         if (int'(new_i) <= PERM_TOP && int'(old_i) <= PERM_TOP)
            le_o = LE_MAP[int'(new_i)*LVLS + int'(old_i)];
      end
   end else begin : g_logic
      logic new_ok, old_ok;
      assign new_ok = int'(new_i) <= PERM_TOP;
      assign old_ok = int'(old_i) <= PERM_TOP;
      assign le_o = new_ok && old_ok &&
                    ((new_i == old_i) || (new_i == '0) ||
                     (new_i == PERM_W'(1) && old_i != '0) ||
                     (old_i == PERM_W'(PERM_TOP)));
   end

endmodule

// File: rtl/capx_check.sv
module capx_check
   import capx_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int SEAL_MIN   = 4096,
   parameter bit PERM_TABLE = 1'b0,
   localparam int OPND_W    = META_W + 3*ADDR_W
) (
   input  logic [3:0]        op_i,
   input  logic [OPND_W-1:0] src1_i,
   input  logic [OPND_W-1:0] src2_i,
   input  logic [OPND_W-1:0] dst_i,
   output logic [2:0]        cause_o
);
   typedef struct packed {
      logic               is_cap;
      logic               valid;
      logic [2:0]         ctype;
      logic [PERM_W-1:0]  perms;
      logic [COUNT_W-1:0] count;
      logic [ADDR_W-1:0]  cursor;
      logic [ADDR_W-1:0]  base;
      logic [ADDR_W-1:0]  top;
   } cap_t;

   localparam logic [ADDR_W-1:0] PERM_LIM  = ADDR_W'(PERM_TOP);
   localparam logic [ADDR_W-1:0] COUNT_LIM = ADDR_W'(COUNT_MAX);
   localparam logic [ADDR_W-1:0] SEAL_LEN  = ADDR_W'(SEAL_MIN);

   cap_t s1, s2, d;
   assign s1 = src1_i;
   assign s2 = src2_i;
   assign d  = dst_i;

   logic perm_le;
   capx_perm_order #(.PERM_W(PERM_W), .PERM_TOP(PERM_TOP), .TABLE_IMPL(PERM_TABLE)) u_order (
      .new_i (s1.cursor[PERM_W-1:0]),
      .old_i (d.perms),
      .le_o  (perm_le)
   );

   logic known, kind_ok, valid_ok, type_ok, perm_ok, bounds_ok, count_ok;

   always_comb begin
      known = 1'b1; kind_ok = 1'b1; valid_ok = 1'b1; type_ok = 1'b1;
      perm_ok = 1'b1; bounds_ok = 1'b1; count_ok = 1'b1;
      case (op_e'(op_i))
         OP_MOVE: kind_ok = s1.is_cap;
         OP_INCR: begin
            kind_ok = s1.is_cap && !s2.is_cap;
            type_ok = s1.ctype != T_UNINIT;
         end
         OP_INCI: begin
            kind_ok = s1.is_cap;
            type_ok = s1.ctype != T_UNINIT;
         end
         OP_CSET: begin
            kind_ok = d.is_cap && !s1.is_cap;
            type_ok = !(d.ctype inside {T_UNINIT, T_SEALED, T_SRET});
         end
         OP_CGET: begin
            kind_ok = s1.is_cap;
            type_ok = !(s1.ctype inside {T_SEALED, T_SRET});
         end
         OP_SHRINK: begin
            kind_ok   = d.is_cap && !s1.is_cap && !s2.is_cap;
            type_ok   = d.ctype inside {T_LIN, T_NLIN, T_UNINIT};
            bounds_ok = (s1.cursor <= s2.cursor) && (s1.cursor >= d.base) && (s2.cursor <= d.top);
         end
         OP_SPLIT: begin
            kind_ok   = s1.is_cap && !s2.is_cap;
            type_ok   = s1.ctype inside {T_LIN, T_NLIN};
            bounds_ok = (s2.cursor >= s1.base) && (s2.cursor <= s1.top);
         end
         OP_TIGHTEN: begin
            kind_ok = d.is_cap && !s1.is_cap;
            type_ok = d.ctype inside {T_LIN, T_NLIN, T_UNINIT};
            perm_ok = (s1.cursor <= PERM_LIM) && perm_le;
         end
         OP_DELIN: begin
            kind_ok = d.is_cap;
            type_ok = d.ctype == T_LIN;
         end
         OP_INIT: begin
            kind_ok   = d.is_cap;
            type_ok   = d.ctype == T_UNINIT;
            bounds_ok = d.cursor == d.top;
         end
         OP_SEAL: begin
            kind_ok   = d.is_cap && !s1.is_cap;
            type_ok   = d.ctype == T_LIN;
            perm_ok   = d.perms inside {PERM_W'(3), PERM_W'(4)};
            bounds_ok = (d.top >= d.base) && ((d.top - d.base) >= SEAL_LEN);
            count_ok  = s1.cursor <= COUNT_LIM;
         end
         OP_DROP: kind_ok = s1.is_cap;
         OP_MKREV: begin
            kind_ok  = s1.is_cap;
            valid_ok = s1.valid;
            type_ok  = s1.ctype == T_LIN;
         end
         default: known = 1'b0;
      endcase
   end

   always_comb begin
      if (!known)          cause_o = C_BADOP;
      else if (!kind_ok)   cause_o = C_KIND;
      else if (!valid_ok)  cause_o = C_INVALID;
      else if (!type_ok)   cause_o = C_TYPE;
      else if (!perm_ok)   cause_o = C_PERM;
      else if (!bounds_ok) cause_o = C_BOUNDS;
      else if (!count_ok)  cause_o = C_COUNT;
      else                 cause_o = C_NONE;
   end

   logic unused_fields;
   assign unused_fields = ^{s2.valid, s2.ctype, s2.perms, s2.count, s2.base, s2.top,
                            s1.perms, s1.count, s1.cursor[ADDR_W-1:PERM_W], d.valid, d.count};

endmodule

// File: rtl/capx_build.sv
module capx_build
   import capx_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int IMM_W   = 12,
   localparam int OPND_W = META_W + 3*ADDR_W
) (
   input  logic [3:0]        op_i,
   input  logic              same_reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [OPND_W-1:0] src1_i,
   input  logic [OPND_W-1:0] src2_i,
   input  logic [OPND_W-1:0] dst_i,
   output logic              rd_we_o,
   output logic [OPND_W-1:0] rd_val_o,
   output logic              rs_we_o,
   output logic [OPND_W-1:0] rs_val_o
);
   typedef struct packed {
      logic               is_cap;
      logic               valid;
      logic [2:0]         ctype;
      logic [PERM_W-1:0]  perms;
      logic [COUNT_W-1:0] count;
      logic [ADDR_W-1:0]  cursor;
      logic [ADDR_W-1:0]  base;
      logic [ADDR_W-1:0]  top;
   } cap_t;

   cap_t s1, s2, d, rd, rs, null_cap;
   assign s1 = src1_i;
   assign s2 = src2_i;
   assign d  = dst_i;

   always_comb begin
      null_cap        = '0;
      null_cap.is_cap = 1'b1;
   end

   logic [ADDR_W-1:0] imm_off, off;
   if (IMM_W < ADDR_W) begin : g_sext
      assign imm_off = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
   end else begin : g_trunc
      assign imm_off = imm_i[ADDR_W-1:0];
   end
   assign off = (op_e'(op_i) == OP_INCR) ? s2.cursor : imm_off;

   logic consume;
   assign consume = !same_reg_i && (s1.ctype != T_NLIN);

   always_comb begin
      rd_we_o = 1'b0;
      rs_we_o = 1'b0;
      rd      = s1;
      rs      = null_cap;
      case (op_e'(op_i))
         OP_MOVE: begin
            rd_we_o = !same_reg_i;
            rs_we_o = consume;
         end
         OP_INCR, OP_INCI: begin
            rd_we_o   = !same_reg_i || (off != '0);
            rs_we_o   = consume;
            rd.cursor = s1.cursor + off;
         end
         OP_CSET: begin
            rd_we_o   = 1'b1;
            rd        = d;
            rd.cursor = s1.cursor;
         end
         OP_CGET: begin
            rd_we_o   = 1'b1;
            rd        = '0;
            rd.cursor = s1.cursor;
         end
         OP_SHRINK: begin
            rd_we_o = 1'b1;
            rd      = d;
            rd.base = s1.cursor;
            rd.top  = s2.cursor;
         end
         OP_SPLIT: begin
            rd_we_o = 1'b1;
            rs_we_o = 1'b1;
            rd.base = s2.cursor;
            rs      = s1;
            rs.top  = s2.cursor;
         end
         OP_TIGHTEN: begin
            rd_we_o  = 1'b1;
            rd       = d;
            rd.perms = s1.cursor[PERM_W-1:0];
         end
         OP_DELIN: begin
            rd_we_o  = 1'b1;
            rd       = d;
            rd.ctype = T_NLIN;
         end
         OP_INIT: begin
            rd_we_o  = 1'b1;
            rd       = d;
            rd.ctype = T_LIN;
         end
         OP_SEAL: begin
            rd_we_o  = 1'b1;
            rd       = d;
            rd.ctype = T_SEALED;
            rd.count = s1.cursor[COUNT_W-1:0];
         end
         OP_DROP: begin
            rs_we_o  = 1'b1;
            rs       = s1;
            rs.valid = 1'b0;
         end
         OP_MKREV: begin
            rd_we_o  = 1'b1;
            rd.ctype = T_REV;
         end
         default: ;
      endcase
   end

   assign rd_val_o = rd;
   assign rs_val_o = rs;

   logic unused_fields;
   assign unused_fields = ^{s2.is_cap, s2.valid, s2.ctype, s2.perms, s2.count, s2.base, s2.top};

endmodule

// File: rtl/capx_unit.sv
module capx_unit
   import capx_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int IMM_W      = 12,
   parameter int CAP_BITS   = 128,
   parameter int SEAL_SLOTS = 32,
   parameter bit PERM_TABLE = 1'b0,
   localparam int OPND_W    = META_W + 3*ADDR_W,
   localparam int SEAL_MIN  = CAP_BITS * SEAL_SLOTS
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              go_i,
   input  logic [3:0]        op_i,
   input  logic              same_reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [OPND_W-1:0] src1_i,
   input  logic [OPND_W-1:0] src2_i,
   input  logic [OPND_W-1:0] dst_i,
   output logic              rd_we_o,
   output logic [OPND_W-1:0] rd_val_o,
   output logic              rs_we_o,
   output logic [OPND_W-1:0] rs_val_o,
   output logic              exc_o,
   output logic [2:0]        cause_o
);
   if (ADDR_W < 16) begin : g_bad_addr
      $error("capx_unit: ADDR_W must be at least 16");
   end
   if (IMM_W < 2 || IMM_W > ADDR_W) begin : g_bad_imm
      $error("capx_unit: IMM_W must lie in [2, ADDR_W]");
   end
   if (SEAL_MIN >= 2**(ADDR_W > 30 ? 30 : ADDR_W)) begin : g_bad_seal
      $error("capx_unit: sealing region size does not fit the address width");
   end

   localparam logic [OPND_W-1:0] NULL_CAP = {1'b1, {(OPND_W-1){1'b0}}};
   localparam int VALID_BIT = OPND_W - 2;
   localparam int BASE_LSB  = ADDR_W;

   logic [2:0]        cause_c;
   logic              rd_we_c, rs_we_c;
   logic [OPND_W-1:0] rd_val_c, rs_val_c;

   capx_check #(.ADDR_W(ADDR_W), .SEAL_MIN(SEAL_MIN), .PERM_TABLE(PERM_TABLE)) u_check (
      .op_i    (op_i),
      .src1_i  (src1_i),
      .src2_i  (src2_i),
      .dst_i   (dst_i),
      .cause_o (cause_c)
   );

   capx_build #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_build (
      .op_i       (op_i),
      .same_reg_i (same_reg_i),
      .imm_i      (imm_i),
      .src1_i     (src1_i),
      .src2_i     (src2_i),
      .dst_i      (dst_i),
      .rd_we_o    (rd_we_c),
      .rd_val_o   (rd_val_c),
      .rs_we_o    (rs_we_c),
      .rs_val_o   (rs_val_c)
   );

   logic fault;
   assign fault = cause_c != C_NONE;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_we_o  <= 1'b0;
         rs_we_o  <= 1'b0;
         exc_o    <= 1'b0;
         cause_o  <= C_NONE;
         rd_val_o <= '0;
         rs_val_o <= '0;
      end else begin
         rd_we_o <= go_i && !fault && rd_we_c;
         rs_we_o <= go_i && !fault && rs_we_c;
         exc_o   <= go_i && fault;
         cause_o <= go_i ? cause_c : C_NONE;
         if (go_i) begin
            rd_val_o <= rd_val_c;
            rs_val_o <= rs_val_c;
         end
      end
   end

   // R12: a fault blocks every write and always names its cause
   a_r12_fault_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exc_o |-> (!rd_we_o && !rs_we_o && cause_o != 3'd0));

   // R1: nothing is reported unless an issue was sampled on the previous edge
   a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(go_i) |-> (!exc_o && !rd_we_o && !rs_we_o));

   // R12: the exception strobe lasts one cycle unless issues follow back to back
   a_r12_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_o && !$past(go_i, 1)) |-> 1'b0);

   // R3: a consumed move source is written back as the null capability
   a_r3_move_leaves_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_we_o && $past(op_i) == 4'(OP_MOVE)) |-> rs_val_o == NULL_CAP);

   // R7: the two halves of a split meet at the split point
   a_r7_split_meets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_we_o && $past(op_i) == 4'(OP_SPLIT)) |->
         (rs_we_o && rd_val_o[BASE_LSB +: ADDR_W] == rs_val_o[ADDR_W-1:0]));

   // R11: a drop writes back an invalid copy and leaves the destination alone
   a_r11_drop_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rs_we_o && $past(op_i) == 4'(OP_DROP)) |-> (!rs_val_o[VALID_BIT] && !rd_we_o));

endmodule

// File: tb/capx_unit_tb_top.sv
module capx_unit_tb_top;
   localparam int AW = 64;
   localparam int OW = 13 + 3*AW;

   typedef struct packed {
      logic          is_cap;
      logic          valid;
      logic [2:0]    ctype;
      logic [2:0]    perms;
      logic [4:0]    count;
      logic [AW-1:0] cursor;
      logic [AW-1:0] base;
      logic [AW-1:0] top;
   } cap_t;

   localparam logic [3:0] MOVE = 0, INCR = 1, INCI = 2, CSET = 3, CGET = 4, SHRINK = 5,
                          SPLIT = 6, TIGHTEN = 7, DELIN = 8, INIT = 9, SEAL = 10,
                          DROP = 11, MKREV = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0;
   logic [3:0] op = '0;
   logic same = 1'b0;
   logic [11:0] imm = '0;
   cap_t s1 = '0, s2 = '0, dd = '0;
   logic rd_we, rs_we, exc;
   logic [2:0] cause;
   cap_t rd_val, rs_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   capx_unit dut_i (
      .clk_i (clk), .rst_ni (rst_n), .go_i (go), .op_i (op), .same_reg_i (same),
      .imm_i (imm), .src1_i (s1), .src2_i (s2), .dst_i (dd),
      .rd_we_o (rd_we), .rd_val_o (rd_val), .rs_we_o (rs_we), .rs_val_o (rs_val),
      .exc_o (exc), .cause_o (cause)
   );

   function automatic cap_t mk(bit c, bit v, int t, int p, int n, longint cur, longint b, longint e);
      cap_t r;
      r.is_cap = c; r.valid = v; r.ctype = 3'(t); r.perms = 3'(p); r.count = 5'(n);
      r.cursor = cur; r.base = b; r.top = e;
      return r;
   endfunction

   function automatic cap_t iv(longint v);
      return mk(0, 0, 0, 0, 0, v, 0, 0);
   endfunction

   function automatic bit perm_below(logic [AW-1:0] n, logic [2:0] o);
      if (n > 4 || o > 4) return 0;
      if (n == o || n == 0) return 1;
      if (n == 1) return o != 0;
      return o == 4;
   endfunction

   function automatic void model(input logic [3:0] o, input cap_t a, input cap_t b, input cap_t d,
                                 input logic [11:0] im, input bit sm,
                                 output bit e_exc, output logic [2:0] e_cause,
                                 output bit e_rdwe, output cap_t e_rd,
                                 output bit e_rswe, output cap_t e_rs);
      bit kind = 1, vld = 1, typ = 1, prm = 1, bnd = 1, cnt = 1, known = 1;
      logic [AW-1:0] offs;
      cap_t nul = mk(1, 0, 0, 0, 0, 0, 0, 0);
      e_rdwe = 0; e_rswe = 0; e_rd = a; e_rs = nul;
      offs = (o == INCR) ? b.cursor : {{(AW-12){im[11]}}, im};
      case (o)
         MOVE: begin kind = a.is_cap; e_rdwe = !sm; e_rswe = !sm && a.ctype != 1; end
         INCR, INCI: begin
            kind = a.is_cap && (o == INCI || !b.is_cap);
            typ = a.ctype != 3;
            e_rdwe = !sm || offs != 0; e_rswe = !sm && a.ctype != 1;
            e_rd.cursor = a.cursor + offs;
         end
         CSET: begin
            kind = d.is_cap && !a.is_cap; typ = d.ctype < 3 || d.ctype > 5;
            e_rdwe = 1; e_rd = d; e_rd.cursor = a.cursor;
         end
         CGET: begin
            kind = a.is_cap; typ = a.ctype != 4 && a.ctype != 5;
            e_rdwe = 1; e_rd = iv(a.cursor);
         end
         SHRINK: begin
            kind = d.is_cap && !a.is_cap && !b.is_cap;
            typ = d.ctype == 0 || d.ctype == 1 || d.ctype == 3;
            bnd = a.cursor <= b.cursor && a.cursor >= d.base && b.cursor <= d.top;
            e_rdwe = 1; e_rd = d; e_rd.base = a.cursor; e_rd.top = b.cursor;
         end
         SPLIT: begin
            kind = a.is_cap && !b.is_cap; typ = a.ctype == 0 || a.ctype == 1;
            bnd = b.cursor >= a.base && b.cursor <= a.top;
            e_rdwe = 1; e_rswe = 1; e_rd.base = b.cursor; e_rs = a; e_rs.top = b.cursor;
         end
         TIGHTEN: begin
            kind = d.is_cap && !a.is_cap;
            typ = d.ctype == 0 || d.ctype == 1 || d.ctype == 3;
            prm = perm_below(a.cursor, d.perms);
            e_rdwe = 1; e_rd = d; e_rd.perms = a.cursor[2:0];
         end
         DELIN: begin kind = d.is_cap; typ = d.ctype == 0; e_rdwe = 1; e_rd = d; e_rd.ctype = 1; end
         INIT: begin
            kind = d.is_cap; typ = d.ctype == 3; bnd = d.cursor == d.top;
            e_rdwe = 1; e_rd = d; e_rd.ctype = 0;
         end
         SEAL: begin
            kind = d.is_cap && !a.is_cap; typ = d.ctype == 0;
            prm = d.perms == 3 || d.perms == 4;
            bnd = d.top >= d.base && d.top - d.base >= 4096;
            cnt = a.cursor <= 31;
            e_rdwe = 1; e_rd = d; e_rd.ctype = 4; e_rd.count = a.cursor[4:0];
         end
         DROP: begin kind = a.is_cap; e_rswe = 1; e_rs = a; e_rs.valid = 0; end
         MKREV: begin
            kind = a.is_cap; vld = a.valid; typ = a.ctype == 0;
            e_rdwe = 1; e_rd.ctype = 2;
         end
         default: known = 0;
      endcase
      if (!known) e_cause = 7;
      else if (!kind) e_cause = 1;
      else if (!vld) e_cause = 2;
      else if (!typ) e_cause = 3;
      else if (!prm) e_cause = 4;
      else if (!bnd) e_cause = 5;
      else if (!cnt) e_cause = 6;
      else e_cause = 0;
      e_exc = e_cause != 0;
      if (e_exc) begin e_rdwe = 0; e_rswe = 0; end
   endfunction

   function automatic string req_of(logic [3:0] o);
      case (o)
         MOVE: return "R3";
         INCR, INCI: return "R4";
         CSET, CGET: return "R5";
         SHRINK: return "R6";
         SPLIT: return "R7";
         TIGHTEN: return "R8";
         DELIN, INIT: return "R9";
         SEAL: return "R10";
         DROP, MKREV: return "R11";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string tag, bit ok, logic [OW-1:0] act, logic [OW-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic issue(logic [3:0] o, cap_t a, cap_t b, cap_t d, logic [11:0] im, bit sm, string tag);
      bit e_exc, e_rdwe, e_rswe;
      logic [2:0] e_cause;
      cap_t e_rd, e_rs;
      bit ok;
      @(negedge clk);
      op = o; s1 = a; s2 = b; dd = d; imm = im; same = sm; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      model(o, a, b, d, im, sm, e_exc, e_cause, e_rdwe, e_rd, e_rswe, e_rs);
      ok = exc == e_exc && cause == e_cause && rd_we == e_rdwe && rs_we == e_rswe &&
           (!e_rdwe || rd_val == e_rd) && (!e_rswe || rs_val == e_rs);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s op=%0d actual exc=%0b cause=%0d rdwe=%0b rswe=%0b rd=%h rs=%h expected exc=%0b cause=%0d rdwe=%0b rswe=%0b rd=%h rs=%h",
                  tag, o, exc, cause, rd_we, rs_we, rd_val, rs_val,
                  e_exc, e_cause, e_rdwe, e_rswe, e_rd, e_rs);
      end
   endtask

   task automatic idle_check(string tag);
      @(negedge clk);
      chk(tag, !exc && !rd_we && !rs_we, OW'({exc, rd_we, rs_we}), '0);
   endtask

   function automatic cap_t rnd_opnd();
      cap_t r;
      longint len;
      int pick;
      r.is_cap = ($urandom % 8) != 0;
      r.valid  = ($urandom % 4) != 0;
      r.ctype  = 3'($urandom % 6);
      r.perms  = 3'($urandom % 5);
      r.count  = 5'($urandom);
      r.base   = longint'($urandom % 8192);
      pick = $urandom % 3;
      len = (pick == 0) ? longint'($urandom % 64) :
            (pick == 1) ? longint'(4095 + $urandom % 3) : longint'($urandom % 10000);
      r.top = r.base + len;
      pick = $urandom % 3;
      r.cursor = (pick == 0) ? r.top : (pick == 1) ? r.base : r.base + longint'($urandom % (len + 1));
      if (!r.is_cap) r.cursor = ($urandom % 3 == 0) ? longint'($urandom % 40) : longint'($urandom % 12000);
      return r;
   endfunction

   cap_t lin, nlin, unin;

   initial begin
      lin  = mk(1, 1, 0, 3, 0, 200, 100, 300);
      nlin = mk(1, 1, 1, 4, 0, 200, 100, 300);
      unin = mk(1, 1, 3, 3, 0, 250, 100, 300);
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", !exc && !rd_we && !rs_we && cause == 0,
          OW'({exc, rd_we, rs_we, cause}), '0);
      rst_n = 1'b1;
      idle_check("R1 idle after reset");

      issue(MOVE, lin, iv(0), iv(0), 0, 0, "R3 move linear");
      chk("R3 linear source nulled", rs_we && rs_val == mk(1, 0, 0, 0, 0, 0, 0, 0), rs_val, mk(1, 0, 0, 0, 0, 0, 0, 0));
      chk("R3 move copies", rd_we && rd_val == lin, rd_val, lin);
      idle_check("R1 quiet after move");
      issue(MOVE, nlin, iv(0), iv(0), 0, 0, "R3 move non-linear");
      chk("R3 non-linear source kept", !rs_we, OW'(rs_we), '0);
      issue(MOVE, lin, iv(0), iv(0), 0, 1, "R3 move same register");
      chk("R3 same register no write", !rd_we && !rs_we, OW'({rd_we, rs_we}), '0);

      issue(INCI, lin, iv(0), iv(0), 12'hFFF, 0, "R4 negative immediate");
      chk("R4 cursor minus one", rd_val.cursor == 199, rd_val.cursor, 199);
      issue(INCI, nlin, iv(0), iv(0), 12'h000, 0, "R4 zero offset as move");
      chk("R4 zero offset copies", rd_we && rd_val == nlin && !rs_we, rd_val, nlin);
      issue(INCR, unin, iv(5), iv(0), 0, 0, "R4 uninitialised increment");
      chk("R4 cause type", exc && cause == 3, OW'(cause), 3);

      issue(CGET, lin, iv(0), iv(0), 0, 0, "R5 cursor get");
      chk("R5 get returns integer", rd_val == iv(200), rd_val, iv(200));
      issue(CSET, iv(7), iv(0), mk(1, 1, 4, 3, 0, 0, 0, 8000), 0, 0, "R5 set on sealed");
      chk("R5 set sealed faults", cause == 3, OW'(cause), 3);

      issue(SHRINK, iv(150), iv(250), lin, 0, 0, "R6 shrink inside");
      chk("R6 new bounds", rd_val.base == 150 && rd_val.top == 250, OW'({rd_val.base, rd_val.top}), OW'({64'd150, 64'd250}));
      issue(SHRINK, iv(90), iv(250), lin, 0, 0, "R6 shrink below base");
      chk("R6 cause bounds", cause == 5, OW'(cause), 5);
      issue(SHRINK, lin, iv(250), lin, 0, 0, "R2 wrong kind");
      chk("R2 cause kind", cause == 1, OW'(cause), 1);
      issue(4'd15, lin, iv(0), lin, 0, 0, "R2 unknown op");
      chk("R2 cause badop", cause == 7, OW'(cause), 7);

      issue(SPLIT, lin, iv(300), iv(0), 0, 0, "R7 split at end");
      chk("R7 halves", rd_val.base == 300 && rs_val.top == 300 && !exc, OW'({rd_val.base, rs_val.top}), OW'({64'd300, 64'd300}));
      issue(SPLIT, lin, iv(301), iv(0), 0, 0, "R7 split past end");
      chk("R7 cause bounds", cause == 5, OW'(cause), 5);

      issue(TIGHTEN, iv(2), iv(0), lin, 0, 0, "R8 RX under RW");
      chk("R8 incomparable faults", cause == 4, OW'(cause), 4);
      issue(TIGHTEN, iv(2), iv(0), nlin, 0, 0, "R8 RX under RWX");
      chk("R8 tightened", !exc && rd_val.perms == 2, OW'(rd_val.perms), 2);

      issue(INIT, iv(0), iv(0), unin, 0, 0, "R9 init cursor short");
      chk("R9 cause bounds", cause == 5, OW'(cause), 5);
      issue(DELIN, iv(0), iv(0), lin, 0, 0, "R9 delinearise");
      chk("R9 type non-linear", rd_val.ctype == 1, OW'(rd_val.ctype), 1);

      issue(SEAL, iv(31), iv(0), mk(1, 1, 0, 4, 0, 0, 1000, 5096), 0, 0, "R10 seal exact size");
      chk("R10 sealed with count", !exc && rd_val.ctype == 4 && rd_val.count == 31, OW'({rd_val.ctype, rd_val.count}), OW'({3'd4, 5'd31}));
      issue(SEAL, iv(3), iv(0), mk(1, 1, 0, 4, 0, 0, 1000, 5095), 0, 0, "R10 seal short region");
      chk("R10 cause bounds", cause == 5, OW'(cause), 5);
      issue(SEAL, iv(32), iv(0), mk(1, 1, 0, 3, 0, 0, 0, 4096), 0, 0, "R10 seal count");
      chk("R10 cause count", cause == 6, OW'(cause), 6);

      issue(DROP, lin, iv(0), iv(0), 0, 0, "R11 drop");
      chk("R11 dropped invalid", rs_we && !rs_val.valid && !rd_we, OW'({rs_we, rs_val.valid, rd_we}), OW'(3'b100));
      issue(MKREV, mk(1, 0, 0, 3, 0, 0, 0, 64), iv(0), iv(0), 0, 0, "R11 revoke from invalid");
      chk("R12 fault strobe", exc && !rd_we && !rs_we && cause == 2, OW'({exc, rd_we, rs_we, cause}), OW'(6'b100010));
      idle_check("R12 strobe drops");

      for (int i = 0; i < 3000; i++) begin
         logic [3:0] o = 4'($urandom % 16);
         issue(o, rnd_opnd(), rnd_opnd(), rnd_opnd(), 12'($urandom), ($urandom % 4) == 0, req_of(o));
         if (i % 50 == 0) idle_check("R1 random idle");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule